// File: doc/BRIEF.md
# SPI Register-Access Frame Engine

This block is the host side of a serial link to an external network controller. It carries out one register or buffer access for each start request. An access is a single SPI frame with three phases. First a register offset goes out on the line, most significant byte first. Next comes a header byte that says which register space is meant, whether the access reads or writes, and how long the data phase is. Last comes the data phase. The header's length code chooses a fixed length of one, two or four bytes, or an open length that the user ends.

The user starts a frame with a one-cycle `start` pulse, together with the offset, space select, direction and length code. The engine fetches each data byte through a request strobe. For a write the byte goes out on MOSI. For a read the slave's byte comes back with a one-cycle valid strobe. In open-length mode the user marks the final byte with a last flag. Serial timing is SPI mode 0. The serial clock half period is `CLK_DIV` system clocks.

Top module: `spi_frame_engine`

## Requirements
- R1: A frame shifts the ADDR_W-bit offset first, most significant byte first, then the header byte, then the data bytes. Every byte leaves MSB first on `mosi`.
- R2: The header byte is {`blk_sel`[4:0], `wr_en`, `len_mode`[1:0]}. `blk_sel` sits in bits 7:3, the direction in bit 2 and the length code in bits 1:0. Space 5'b00000 is the common register space and 5'b00001 is socket 0's space.
- R3: `wr_en`=1 is a write, and each data byte sent is the `wr_data` byte taken at its request. `wr_en`=0 is a read, and `mosi` is 0 for the whole data phase.
- R4: Length codes 2'b01, 2'b10 and 2'b11 give exactly 1, 2 and 4 data bytes. In these modes `wr_last` has no effect.
- R5: Length code 2'b00 keeps sending data bytes until one is sent whose `wr_last` was high at its request.
- R6: SPI mode 0. `sclk` is low whenever `cs_n` is high. `mosi` changes only at a falling `sclk` edge or when the frame opens. Each `sclk` half period lasts `CLK_DIV` clocks, and the first rising edge comes `CLK_DIV` clocks after `cs_n` falls.
- R7: `cs_n` falls on the clock edge that accepts `start` and stays low through the whole frame. It rises `CLK_DIV` clocks after the last falling `sclk` edge. `done` pulses for one cycle together with that rise.
- R8: `data_req` pulses for one cycle per data byte, in the cycle of the falling edge that ends the byte before it. `wr_data` and `wr_last` are sampled in that cycle.
- R9: On a read, `rd_valid` pulses once per data byte, one cycle after the byte's eighth rising `sclk` edge. `rd_data` then holds the `miso` bits sampled on the rising edges, MSB first. On a write, `rd_valid` never rises.
- R10: `busy` is high from the `cs_n` fall to the `cs_n` rise. A `start` pulse while busy is ignored and does not change the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a frame (taken only when idle) |
| addr | input | ADDR_W | Register offset |
| blk_sel | input | BSB_W | Register space select |
| wr_en | input | 1 | 1 write, 0 read |
| len_mode | input | OM_W | Data-phase length code |
| wr_data | input | BYTE_W | Next data byte to send |
| wr_last | input | 1 | Marks the final byte in open-length mode |
| data_req | output | 1 | Engine takes wr_data/wr_last this cycle |
| rd_data | output | BYTE_W | Received byte |
| rd_valid | output | 1 | rd_data valid strobe |
| done | output | 1 | Frame finished pulse |
| busy | output | 1 | Frame in progress |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench goes after the byte boundaries. If the header is packed in the wrong bit order, or the offset bytes are swapped, the mismatch shows on `mosi` at a known bit. If `data_req` comes one tick early or late, the wrong `wr_data` byte goes out. The length modes are driven with a misplaced `wr_last` in the fixed modes: a design that obeys it there cuts the frame short and raises `cs_n` early. A `start` pulse in the middle of a frame would restart the offset bits if it were not ignored. A read that samples `miso` on the wrong edge returns `rd_data` shifted by one bit.

// File: rtl/spife_pkg.sv
package spife_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_HDR,
      ST_DATA,
      ST_TAIL
   } spife_state_e;

   localparam logic [1:0] LEN_OPEN = 2'b00;
   localparam logic [1:0] LEN_ONE  = 2'b01;
   localparam logic [1:0] LEN_TWO  = 2'b10;
   localparam logic [1:0] LEN_FOUR = 2'b11;

   // number of data bytes for a fixed length code (0 for the open code)
   function automatic logic [2:0] fixed_len(input logic [1:0] code);
      case (code)
         LEN_ONE:  fixed_len = 3'd1;
         LEN_TWO:  fixed_len = 3'd2;
         LEN_FOUR: fixed_len = 3'd4;
         default:  fixed_len = 3'd0;
      endcase
   endfunction

endpackage

// File: rtl/spife_clkdiv.sv
module spife_clkdiv #(
   parameter int DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cnt_en,
   input  logic sclk_en,
   output logic sclk,
   output logic tick,
   output logic rise,
   output logic fall
);

   generate
      if (DIV == 1) begin : g_nodiv
         assign tick = cnt_en;
      end else begin : g_div
         localparam int CW = $clog2(DIV);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt <= '0;
            else if (!cnt_en || tick)
               cnt <= '0;
            else
               cnt <= cnt + 1'b1;
         end
         assign tick = cnt_en && (cnt == CW'(DIV - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sclk <= 1'b0;
      else if (!sclk_en)
         sclk <= 1'b0;
      else if (tick)
         sclk <= ~sclk;
   end

   assign rise = tick && sclk_en && !sclk;
   assign fall = tick && sclk_en && sclk;

endmodule

// File: rtl/spife_shift.sv
module spife_shift #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         shift,
   input  logic         sample,
   input  logic         miso,
   output logic         mosi,
   output logic [W-1:0] rx_next
);

   logic [W-1:0] sh_out;
   logic [W-1:0] sh_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sh_out <= '0;
      else if (load)
         sh_out <= load_val;
      else if (shift)
         sh_out <= {sh_out[W-2:0], 1'b0};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sh_in <= '0;
      else if (sample)
         sh_in <= rx_next;
   end

   assign rx_next = {sh_in[W-2:0], miso};
   assign mosi    = sh_out[W-1];

endmodule

// File: rtl/spife_ctrl.sv
module spife_ctrl
   import spife_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int BSB_W  = 5,
   parameter int OM_W   = 2,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BSB_W-1:0]  blk_sel,
   input  logic              wr_en,
   input  logic [OM_W-1:0]   len_mode,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              wr_last,
   input  logic              tick,
   input  logic              rise,
   input  logic              fall,
   input  logic [BYTE_W-1:0] rx_next,
   output logic              cnt_en,
   output logic              sclk_en,
   output logic              load,
   output logic [BYTE_W-1:0] load_val,
   output logic              data_req,
   output logic [BYTE_W-1:0] rd_data,
   output logic              rd_valid,
   output logic              done,
   output logic              busy,
   output logic              cs_n
);

   localparam int ABYTES = ADDR_W / BYTE_W;
   localparam int AB_W   = (ABYTES > 1) ? $clog2(ABYTES) : 1;
   localparam int BC_W   = $clog2(BYTE_W);

   spife_state_e      state;
   logic [BC_W-1:0]   bit_cnt;
   logic [AB_W-1:0]   abyte;
   logic [ADDR_W-1:0] addr_r;
   logic [ADDR_W-1:0] addr_sh;
   logic [BSB_W-1:0]  bsb_r;
   logic              wr_r;
   logic [OM_W-1:0]   om_r;
   logic [2:0]        data_cnt;
   logic              last_r;
   logic              byte_end;
   logic              data_fin;
   logic [BYTE_W-1:0] hdr_byte;
   logic [BYTE_W-1:0] out_byte;

   assign byte_end = fall && (bit_cnt == BC_W'(BYTE_W - 1));
   assign data_fin = (om_r == LEN_OPEN) ? last_r : (data_cnt == fixed_len(om_r));
   assign hdr_byte = {bsb_r, wr_r, om_r};
   assign out_byte = wr_r ? wr_data : '0;
   assign addr_sh  = addr_r << BYTE_W;

   assign cnt_en   = (state != ST_IDLE);
   assign sclk_en  = (state == ST_ADDR) || (state == ST_HDR) || (state == ST_DATA);
   assign busy     = (state != ST_IDLE);
   assign data_req = byte_end && ((state == ST_HDR) || ((state == ST_DATA) && !data_fin));

   always_comb begin
      load     = 1'b0;
      load_val = '0;
      case (state)
         ST_IDLE: begin
            load     = start;
            load_val = addr[ADDR_W-1 -: BYTE_W];
         end
         ST_ADDR: begin
            load     = byte_end;
            load_val = (abyte == AB_W'(ABYTES - 1)) ? hdr_byte : addr_sh[ADDR_W-1 -: BYTE_W];
         end
         ST_HDR: begin
            load     = byte_end;
            load_val = out_byte;
         end
         ST_DATA: begin
            load     = byte_end;
            load_val = data_fin ? '0 : out_byte;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cs_n     <= 1'b1;
         done     <= 1'b0;
         bit_cnt  <= '0;
         abyte    <= '0;
         addr_r   <= '0;
         bsb_r    <= '0;
         wr_r     <= 1'b0;
         om_r     <= '0;
         data_cnt <= '0;
         last_r   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (fall)
            bit_cnt <= bit_cnt + 1'b1;
         case (state)
            ST_IDLE: begin
               if (start) begin
                  state   <= ST_ADDR;
                  cs_n    <= 1'b0;
                  bit_cnt <= '0;
                  abyte   <= '0;
                  addr_r  <= addr;
                  bsb_r   <= blk_sel;
                  wr_r    <= wr_en;
                  om_r    <= len_mode;
               end
            end
            ST_ADDR: begin
               if (byte_end) begin
                  addr_r <= addr_sh;
                  abyte  <= abyte + 1'b1;
                  if (abyte == AB_W'(ABYTES - 1))
                     state <= ST_HDR;
               end
            end
            ST_HDR: begin
               if (byte_end) begin
                  state    <= ST_DATA;
                  data_cnt <= 3'd1;
                  last_r   <= wr_last;
               end
            end
            ST_DATA: begin
               if (byte_end) begin
                  if (data_fin) begin
                     state <= ST_TAIL;
                  end else begin
                     if (data_cnt != 3'd7)
                        data_cnt <= data_cnt + 3'd1;
                     last_r <= wr_last;
                  end
               end
            end
            ST_TAIL: begin
               if (tick) begin
                  state <= ST_IDLE;
                  cs_n  <= 1'b1;
                  done  <= 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= 1'b0;
         if ((state == ST_DATA) && !wr_r && rise && (bit_cnt == BC_W'(BYTE_W - 1))) begin
            rd_valid <= 1'b1;
            rd_data  <= rx_next;
         end
      end
   end

endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine #(
   parameter int CLK_DIV = 2,
   parameter int ADDR_W  = 16,
   parameter int BSB_W   = 5,
   parameter int OM_W    = 2,
   parameter int BYTE_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BSB_W-1:0]  blk_sel,
   input  logic              wr_en,
   input  logic [OM_W-1:0]   len_mode,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              wr_last,
   output logic              data_req,
   output logic [BYTE_W-1:0] rd_data,
   output logic              rd_valid,
   output logic              done,
   output logic              busy,
   output logic              sclk,
   output logic              cs_n,
   output logic              mosi,
   input  logic              miso
);

   generate
      if (CLK_DIV < 1) begin : g_bad_div
         $error("CLK_DIV must be at least 1");
      end
      if (BSB_W + 1 + OM_W != BYTE_W) begin : g_bad_hdr
         $error("header fields must fill exactly one byte");
      end
      if ((ADDR_W % BYTE_W) != 0 || ADDR_W < BYTE_W) begin : g_bad_addr
         $error("ADDR_W must be a whole number of bytes");
      end
      if (OM_W != 2) begin : g_bad_om
         $error("length code is two bits wide");
      end
   endgenerate

   logic              tick, rise, fall;
   logic              cnt_en, sclk_en;
   logic              load;
   logic [BYTE_W-1:0] load_val;
   logic [BYTE_W-1:0] rx_next;

   spife_clkdiv #(.DIV(CLK_DIV)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .cnt_en  (cnt_en),
      .sclk_en (sclk_en),
      .sclk    (sclk),
      .tick    (tick),
      .rise    (rise),
      .fall    (fall)
   );

   spife_shift #(.W(BYTE_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_val (load_val),
      .shift    (fall),
      .sample   (rise),
      .miso     (miso),
      .mosi     (mosi),
      .rx_next  (rx_next)
   );

   spife_ctrl #(
      .ADDR_W (ADDR_W),
      .BSB_W  (BSB_W),
      .OM_W   (OM_W),
      .BYTE_W (BYTE_W)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .addr     (addr),
      .blk_sel  (blk_sel),
      .wr_en    (wr_en),
      .len_mode (len_mode),
      .wr_data  (wr_data),
      .wr_last  (wr_last),
      .tick     (tick),
      .rise     (rise),
      .fall     (fall),
      .rx_next  (rx_next),
      .cnt_en   (cnt_en),
      .sclk_en  (sclk_en),
      .load     (load),
      .load_val (load_val),
      .data_req (data_req),
      .rd_data  (rd_data),
      .rd_valid (rd_valid),
      .done     (done),
      .busy     (busy),
      .cs_n     (cs_n)
   );

endmodule

// File: rtl/spife_chk.sv
module spife_chk (
   input logic clk,
   input logic rst_n,
   input logic cs_n,
   input logic sclk,
   input logic mosi,
   input logic busy,
   input logic done,
   input logic rd_valid,
   input logic data_req
);

   a_r6_sclk_low_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sclk);

   a_r6_mosi_stable_while_high: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk && $past(sclk)) |-> $stable(mosi));

   a_r7_done_with_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |-> done);

   a_r7_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r8_req_inside_frame: assert property (@(posedge clk) disable iff (!rst_n)
      data_req |-> (!cs_n && sclk));

   a_r9_rdvalid_inside_frame: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> !cs_n);

   a_r10_idle_deselected: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> cs_n);

endmodule

bind spi_frame_engine spife_chk u_spife_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cs_n     (cs_n),
   .sclk     (sclk),
   .mosi     (mosi),
   .busy     (busy),
   .done     (done),
   .rd_valid (rd_valid),
   .data_req (data_req)
);

// File: tb/tb_spi_frame_engine.sv
module tb_spi_frame_engine;

   localparam int DIV = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] addr = '0;
   logic [4:0]  blk_sel = '0;
   logic        wr_en = 1'b0;
   logic [1:0]  len_mode = '0;
   logic [7:0]  wr_data = '0;
   logic        wr_last = 1'b0;
   logic        miso = 1'b0;
   logic        data_req, rd_valid, done, busy, sclk, cs_n, mosi;
   logic [7:0]  rd_data;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   spi_frame_engine #(.CLK_DIV(DIV)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .addr(addr), .blk_sel(blk_sel),
      .wr_en(wr_en), .len_mode(len_mode), .wr_data(wr_data), .wr_last(wr_last),
      .data_req(data_req), .rd_data(rd_data), .rd_valid(rd_valid), .done(done),
      .busy(busy), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // one frame against a per-cycle model; n data bytes, lastk = index carrying wr_last
   task automatic run_frame(input logic [15:0] a, input logic [4:0] b, input logic w,
                            input logic [1:0] om, input int n, input int lastk,
                            input logic [7:0] wd [8], input logic [7:0] rsp [8],
                            input bit poke);
      logic bits[$];
      int   nb, total, reqs, rds;
      logic [7:0] hdr;
      hdr = {b, w, om};
      for (int i = 15; i >= 0; i--) bits.push_back(a[i]);
      for (int i = 7; i >= 0; i--) bits.push_back(hdr[i]);
      for (int k = 0; k < n; k++)
         for (int i = 7; i >= 0; i--) bits.push_back(w ? wd[k][i] : 1'b0);
      nb    = 3 + n;
      total = (16 * nb + 1) * DIV;
      reqs  = 0;
      rds   = 0;
      @(negedge clk);
      start = 1'b1; addr = a; blk_sel = b; wr_en = w; len_mode = om;
      @(negedge clk);
      start = 1'b0;
      for (int c = 0; c <= total + 3; c++) begin
         int  j, jj, bi, bo;
         logic e_sclk, e_mosi, e_req, e_rdv;
         string mtag;
         j  = c / DIV;
         jj = (c + 1) / DIV;
         e_sclk = (j < 16 * nb) ? logic'(j % 2) : 1'b0;
         e_mosi = (j < 16 * nb) ? bits[j / 2] : 1'b0;
         e_req  = ((c + 1) % DIV == 0) && (jj % 16 == 0) && (jj >= 48) && (jj <= 16 * (2 + n));
         bi     = (j - 1) / 2;
         e_rdv  = !w && (c % DIV == 0) && (j % 2 == 1) && (bi % 8 == 7) && (bi >= 24) && (bi < 8 * nb);
         bo     = j / 2;
         mtag   = (bo < 16) ? "R1 offset bit" : (bo < 24) ? "R2 header bit" :
                  (w ? "R3 write data bit" : "R3 read mosi zero");
         check("R6 sclk", sclk, e_sclk);
         check(mtag, mosi, e_mosi);
         check("R7 cs_n", cs_n, (c < total) ? 1'b0 : 1'b1);
         check("R7 done", done, (c == total));
         check("R8 data_req", data_req, e_req);
         check("R9 rd_valid", rd_valid, e_rdv);
         check("R10 busy", busy, (c < total));
         if (rd_valid) begin
            check("R9 rd_data", rd_data, (rds < n) ? rsp[rds] : 8'h00);
            rds++;
         end
         // slave drives next bit for the coming rising edge
         if (bo >= 24 && bo < 8 * nb) miso = rsp[(bo - 24) / 8][7 - (bo % 8)];
         else miso = 1'b0;
         wr_data = (reqs < 8) ? wd[reqs] : 8'h00;
         wr_last = (reqs == lastk);
         if (data_req) reqs++;
         start = poke && (c == 40);
         if (poke && c == 40) begin
            addr = ~a; blk_sel = ~b; wr_en = ~w; len_mode = ~om;
         end
         @(negedge clk);
      end
      start = 1'b0;
      check((om == 2'b00) ? "R5 byte count" : "R4 byte count", reqs, n);
      check("R9 read count", rds, w ? 0 : n);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R7 reset cs_n", cs_n, 1'b1);
      check("R6 reset sclk", sclk, 1'b0);
      check("R10 reset busy", busy, 1'b0);
      check("R7 reset done", done, 1'b0);
      check("R9 reset rd_valid", rd_valid, 1'b0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      // R4 one byte write, common space
      run_frame(16'hA50F, 5'b00000, 1'b1, 2'b01, 1, 0,
                '{8'h3C,0,0,0,0,0,0,0}, '{0,0,0,0,0,0,0,0}, 0);
      // R4 two byte write, socket 0 space, last flag on first byte ignored
      run_frame(16'h0004, 5'b00001, 1'b1, 2'b10, 2, 0,
                '{8'h81,8'h7E,0,0,0,0,0,0}, '{0,0,0,0,0,0,0,0}, 0);
      // R4 four byte write, last flag ignored
      run_frame(16'h1234, 5'b10110, 1'b1, 2'b11, 4, 0,
                '{8'hDE,8'hAD,8'hBE,8'hEF,0,0,0,0}, '{0,0,0,0,0,0,0,0}, 0);
      // R9 one byte read
      run_frame(16'h0039, 5'b00000, 1'b0, 2'b01, 1, 0,
                '{8'hFF,0,0,0,0,0,0,0}, '{8'hC3,0,0,0,0,0,0,0}, 0);
      // R9 four byte read
      run_frame(16'hFFFE, 5'b00001, 1'b0, 2'b11, 4, 3,
                '{0,0,0,0,0,0,0,0}, '{8'h01,8'h80,8'h5A,8'hA5,0,0,0,0}, 0);
      // R5 open length write of five bytes
      run_frame(16'h8001, 5'b00010, 1'b1, 2'b00, 5, 4,
                '{8'h11,8'h22,8'h33,8'h44,8'h55,0,0,0}, '{0,0,0,0,0,0,0,0}, 0);
      // R5 open length read of three bytes
      run_frame(16'h4000, 5'b00011, 1'b0, 2'b00, 3, 2,
                '{0,0,0,0,0,0,0,0}, '{8'hF0,8'h0F,8'h96,0,0,0,0,0}, 0);
      // R10 start pulse mid frame ignored
      run_frame(16'h0102, 5'b00001, 1'b1, 2'b00, 1, 0,
                '{8'h99,0,0,0,0,0,0,0}, '{0,0,0,0,0,0,0,0}, 1);
      repeat (4) @(negedge clk);
      check("R10 idle after ignored start", cs_n, 1'b1);
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule